// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines the branch address with the outcomes of the last few branches that the core resolved. A field of low-order address bits picks one row of a table. Each row holds one two-bit saturating counter for every possible value of a small global outcome history. The current history value selects which counter in that row gives the guess.

The fetch side presents an address on the predict port and reads a combinational taken / not-taken answer in the same cycle. When a branch resolves, the core presents its address and real direction on the update port for one cycle. At that clock edge, the counter chosen by that address and the current history moves one step toward the real direction. The outcome is then shifted into the history. No other counter changes. Counter hysteresis means a single surprise does not reverse a strong guess, so a loop branch costs one misprediction per visit rather than two.

Top module: `corr_bpred`

## Requirements
- R1: A clock edge with `rst_n` low sets every counter to weakly not taken (code 01) and clears the history. Afterwards every address predicts not taken.
- R2: `pred_taken` is the upper bit of the counter in row `pred_pc[PC_LSB +: IDX_W]`, in the column equal to the current history value. The counter codes are: 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken.
- R3: A taken update raises the selected counter by one and holds it at 11.
- R4: A not-taken update lowers the selected counter by one and holds it at 00.
- R5: An update changes only the counter in row `upd_pc[PC_LSB +: IDX_W]` and in the column of the history value before the shift. Every other counter keeps its value.
- R6: Each update shifts the history left by one bit and places the resolved direction (1 = taken) in bit 0.
- R7: While `upd_valid` is low, neither the counters nor the history change, whatever `upd_pc` and `upd_taken` carry.
- R8: A counter in a strongly held state keeps its predicted direction after one contrary update. The direction flips only after two contrary updates in a row.
- R9: Address bits outside the index field have no effect on which counter is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken (combinational) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The checker assumes that `upd_valid` and `upd_taken` are known, never X, in every cycle after reset. It also assumes that the history is at least two bits wide, so the shift property can take a slice of it. The bench drives both controls to defined levels on every falling edge from time zero. It uses a four-column, eight-row configuration so that a reference model can cover every counter.

The idle phases toggle `upd_taken` and `upd_pc` with `upd_valid` low, so the hold properties see changing inputs that must be ignored. The sweep phase uses upper address bits from a pseudo-random source. Those addresses stay inside the checked format, since only the index field is decoded.

// File: rtl/corr_bpred_pkg.sv
// Shared counter type and step function for the correlating predictor.
// Assumes: counters are always two bits wide.
package corr_bpred_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_WT  = 2'b10;
    localparam ctr_t CTR_ST  = 2'b11;

    // One saturating step toward the resolved direction.
    function automatic ctr_t ctr_step(ctr_t cur, logic taken);
        ctr_t res;
        if (taken) res = (cur == CTR_ST)  ? CTR_ST  : ctr_t'(cur + 2'd1);
        else       res = (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
        return res;
    endfunction

endpackage

// File: rtl/bp_history.sv
// Global outcome shift register.
// Assumes: shift_en is known after reset; HIST_W >= 2.
module bp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);

    // Clear on reset, otherwise shift the new outcome in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_o <= '0;
        else if (shift_en) hist_o <= {hist_o[HIST_W-2:0], bit_in};
    end

endmodule

// File: rtl/bp_sat_update.sv
// Combinational next-state logic for the one counter under update.
// Assumes: cur is the counter read at the update location this cycle.
module bp_sat_update
    import corr_bpred_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);

    // Step the counter toward the outcome, saturating at both ends.
    always_comb nxt = ctr_step(cur, taken);

endmodule

// File: rtl/bp_counter_table.sv
// Counter storage: ROWS rows by NCOL columns of two-bit counters.
// Each column is its own array, so a write touches one cell only.
// Two read ports: one for prediction, one for the update location.
// Assumes: a single write per cycle, at the update row and column.
module bp_counter_table
    import corr_bpred_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  prd_idx,
    input  logic [HIST_W-1:0] prd_col,
    output ctr_t              prd_ctr,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [HIST_W-1:0] upd_col,
    output ctr_t              upd_ctr,
    input  logic              wr_en,
    input  ctr_t              wr_ctr
);

    localparam int ROWS = 1 << IDX_W;
    localparam int NCOL = 1 << HIST_W;

    ctr_t prd_vec [NCOL];
    ctr_t upd_vec [NCOL];

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        ctr_t cells [ROWS];

        // Reset every cell to weakly not taken; write the chosen cell only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) cells[r] <= CTR_WNT;
            end else if (wr_en && (upd_col == HIST_W'(c))) begin
                cells[upd_idx] <= wr_ctr;
            end
        end

        assign prd_vec[c] = cells[prd_idx];
        assign upd_vec[c] = cells[upd_idx];
    end

    // Column select by history value for both read ports.
    always_comb begin
        prd_ctr = prd_vec[prd_col];
        upd_ctr = upd_vec[upd_col];
    end

endmodule

// File: rtl/corr_bpred.sv
// Correlating two-bit branch direction predictor (top level).
// Index = PC bits [PC_LSB +: IDX_W]; column = global history.
// Assumes: PC_LSB + IDX_W <= PC_W; HIST_W >= 2; updates arrive in
// program order so the history matches the one used at prediction.
module corr_bpred
    import corr_bpred_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 2,
    parameter int PC_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [HIST_W-1:0] ghr_q;
    ctr_t              pred_ctr;
    ctr_t              upd_cur;
    ctr_t              upd_nxt;
    logic              pc_spare_unused;

    // Address fields; bits outside the index are deliberately dropped.
    always_comb begin
        pred_idx        = pred_pc[PC_LSB +: IDX_W];
        upd_idx         = upd_pc[PC_LSB +: IDX_W];
        pc_spare_unused = ^{pred_pc, upd_pc};
    end

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist_o   (ghr_q)
    );

    bp_counter_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .prd_idx (pred_idx),
        .prd_col (ghr_q),
        .prd_ctr (pred_ctr),
        .upd_idx (upd_idx),
        .upd_col (ghr_q),
        .upd_ctr (upd_cur),
        .wr_en   (upd_valid),
        .wr_ctr  (upd_nxt)
    );

    bp_sat_update u_step (
        .cur   (upd_cur),
        .taken (upd_taken),
        .nxt   (upd_nxt)
    );

    // Predict taken when the selected counter's upper bit is set.
    always_comb pred_taken = pred_ctr[1];

endmodule

// File: rtl/corr_bpred_chk.sv
// Property checker for corr_bpred, attached with bind.
// Assumes: upd_valid and upd_taken are known after reset; HIST_W >= 2.
module corr_bpred_chk
    import corr_bpred_pkg::*;
#(
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] hist,
    input ctr_t              upd_cur,
    input ctr_t              upd_nxt,
    input logic              pred_taken
);

    // R1: right after a reset edge no address predicts taken
    assert_reset_not_taken_R1: assert property (@(posedge clk)
        !rst_n |=> !pred_taken);

    // R1: history is empty after a reset edge
    assert_reset_hist_R1: assert property (@(posedge clk)
        !rst_n |=> (hist == '0));

    // R3: a taken update never lowers the counter and moves it at most one step
    assert_taken_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |-> ((upd_nxt >= upd_cur) && (upd_nxt - upd_cur <= 2'd1)
                                      && (upd_nxt != upd_cur || upd_cur == CTR_ST)));

    // R4: a not-taken update never raises the counter and moves it at most one step
    assert_not_taken_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |-> ((upd_nxt <= upd_cur) && (upd_cur - upd_nxt <= 2'd1)
                                       && (upd_nxt != upd_cur || upd_cur == CTR_SNT)));

    // R6: history takes the resolved direction into bit 0 on each update
    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)}));

    // R7: history holds while no update is presented
    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

endmodule

bind corr_bpred corr_bpred_chk #(.HIST_W(HIST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .hist       (ghr_q),
    .upd_cur    (upd_cur),
    .upd_nxt    (upd_nxt),
    .pred_taken (pred_taken)
);

// File: tb/corr_bpred_test.sv
// Bench: small configuration (8 rows x 4 columns) checked against an
// arithmetic reference model after every stimulus step.
module corr_bpred_test;

    localparam int PC_W   = 16;
    localparam int IDX_W  = 3;
    localparam int HIST_W = 2;
    localparam int PC_LSB = 2;
    localparam int ROWS   = 1 << IDX_W;
    localparam int NCOL   = 1 << HIST_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int mdl [ROWS][NCOL];
    int ghr;
    int unsigned seed = 32'h1234_5678;

    corr_bpred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    always #4 clk = ~clk;

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic logic [PC_W-1:0] make_pc(int row, int unsigned noise);
        logic [PC_W-1:0] p;
        p = PC_W'(noise);
        p[PC_LSB +: IDX_W] = IDX_W'(row);
        return p;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < NCOL; c++) mdl[r][c] = 1;
        ghr = 0;
    endtask

    task automatic do_update(logic [PC_W-1:0] pc, bit t);
        int row;
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
        row = int'(pc[PC_LSB +: IDX_W]);
        if (t) mdl[row][ghr] = (mdl[row][ghr] == 3) ? 3 : mdl[row][ghr] + 1;
        else   mdl[row][ghr] = (mdl[row][ghr] == 0) ? 0 : mdl[row][ghr] - 1;
        ghr = ((ghr << 1) | int'(t)) & (NCOL - 1);
    endtask

    task automatic check_pred(logic [PC_W-1:0] pc, string req);
        bit exp;
        exp = (mdl[int'(pc[PC_LSB +: IDX_W])][ghr] >= 2);
        pred_pc = pc;
        #1;
        checks++;
        if (pred_taken !== exp) begin
            errors++;
            $display("FAIL %s pc=%h actual=%b expected=%b", req, pc, pred_taken, exp);
        end
    endtask

    task automatic check_all_rows(string req);
        for (int r = 0; r < ROWS; r++) check_pred(make_pc(r, next_rand()), req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_all_rows("R1");

        // R3: repeated taken updates saturate at strongly taken (history settles at 11)
        for (int i = 0; i < 5; i++) do_update(make_pc(2, 0), 1'b1);
        check_pred(make_pc(2, 0), "R3");
        check_all_rows("R5");

        // R8: one contrary update leaves a strong counter predicting taken
        do_update(make_pc(2, 0), 1'b0);
        do_update(make_pc(5, 0), 1'b1);
        do_update(make_pc(5, 0), 1'b1);
        check_pred(make_pc(2, 0), "R8");
        // R8: a second contrary update in a row flips it
        do_update(make_pc(2, 0), 1'b0);
        do_update(make_pc(6, 0), 1'b1);
        do_update(make_pc(6, 0), 1'b1);
        check_pred(make_pc(2, 0), "R8");

        // R4: repeated not-taken updates saturate at strongly not taken
        do_reset();
        for (int i = 0; i < 5; i++) do_update(make_pc(3, 0), 1'b0);
        do_update(make_pc(3, 0), 1'b1);
        check_pred(make_pc(3, 0), "R4");

        // R6: the history moves the selected column; return to 00 re-exposes the trained cell
        do_reset();
        do_update(make_pc(1, 0), 1'b1);
        check_pred(make_pc(1, 0), "R6");
        do_update(make_pc(4, 0), 1'b0);
        do_update(make_pc(4, 0), 1'b0);
        check_pred(make_pc(1, 0), "R6");
        check_all_rows("R2");

        // R7: update inputs wiggle with upd_valid low; nothing may change
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            upd_pc = make_pc(1, next_rand());
            upd_taken = ~upd_taken;
        end
        check_all_rows("R7");
        do_update(make_pc(7, 0), 1'b1);
        check_all_rows("R7");

        // R9: upper and alignment bits vary; same row must answer alike
        for (int i = 0; i < 16; i++) check_pred(make_pc(1, next_rand()), "R9");
        do_update(make_pc(1, 16'hFFFF), 1'b1);
        check_pred(make_pc(1, 16'h0000), "R9");

        // Sweep: pseudo-random updates, every row checked after each step
        do_reset();
        for (int i = 0; i < 600; i++) begin
            int unsigned rv;
            rv = next_rand();
            do_update(make_pc(int'(rv % ROWS), next_rand()), (rv >> 7) % 3 != 0);
            check_all_rows("R5");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule